// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches nineteen external lines and turns selected edges on them into interrupt requests and event pulses. Each line can be set to fire on rising edges, falling edges or both. A hit is recorded in a per-line pending bit that stays set until software clears it. The sixteen lower lines each take one pin from a choice of five 16-pin general-purpose ports. The three upper lines come straight from dedicated inputs.

Edges are caught by flops clocked by the line itself. A pulse that starts and ends between two rising edges of the bus clock is therefore still seen. The captured toggles are then synchronised into the bus clock domain. Software reaches the block through a plain word-wide register port: the write takes effect on a clock edge, and the read data is combinational. There is no streaming data path, so no valid/ready handshake applies. Every pin is a plain level or a plain pulse.

Top module: `xirq_ctrl`

## Requirements
- R1: Line n (n < 16) follows pin n of the port held in its 3-bit select field; port p pin n is `gpio_i[16*p+n]`. A select value of 5 to 7 holds the line low. Lines 16 to 18 follow `aux_i[0..2]`.
- R2: When bit n of the rising-enable register (address 2) is 1, a 0-to-1 change on line n is a trigger.
- R3: When bit n of the falling-enable register (address 3) is 1, a 1-to-0 change on line n is a trigger.
- R4: A line whose rising and falling enable bits are both 0 never triggers from its input.
- R5: A pulse whose two edges both fall between two rising clock edges is still detected. A pin edge shows up as pending or event after the third rising clock edge that follows it.
- R6: A trigger sets pending bit n only when bit n of the interrupt-enable register (address 0) is 1. `irq_o[n]` shows pending bit n.
- R7: Writing to the pending register (address 5) clears each bit written as 1 and leaves bits written as 0 unchanged. A trigger on the same edge as the clear wins, and the bit stays set.
- R8: A trigger on a line whose event-enable bit (address 1) is 1 drives `event_o` high for one cycle, on the same edge that would set pending. The event does not depend on the interrupt enable, and it does not set pending.
- R9: Writing 1 to bit n of the software-trigger register (address 4) is a trigger on line n, on the write edge. That address always reads 0.
- R10: All registers reset to 0 and read back what was written. Address 6 holds the select fields of lines 0 to 7, and address 7 holds those of lines 8 to 15. Line n uses bits [3*(n mod 8)+2 : 3*(n mod 8)] of its register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gpio_i | input | 80 | Five 16-pin general-purpose ports |
| aux_i | input | 3 | Direct inputs for lines 16 to 18 |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq_o | output | 19 | Per-line interrupt request (pending bits) |
| event_o | output | 1 | One-cycle event pulse |

## Verification
A pin edge lands in `irq_o` and `event_o` after the third rising clock edge that follows it. The bench's reference model holds recorded edges in a two-deep pipeline before applying them. Register writes, software triggers and clears take effect on the same edge that samples the write, and reads are due in the same cycle. The bench drives every stimulus just after a clock edge and compares both outputs with the model 1 ns after every edge. It also makes explicit checks at the cycle just before and just at the due edge.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    A_INT_EN  = 3'd0,
    A_EVT_EN  = 3'd1,
    A_RISE_EN = 3'd2,
    A_FALL_EN = 3'd3,
    A_SW_TRIG = 3'd4,
    A_PEND    = 3'd5,
    A_SEL_LO  = 3'd6,
    A_SEL_HI  = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/xirq_pin_mux.sv
module xirq_pin_mux #(
  parameter int NUM_PORTS = 5,
  parameter int PINS      = 16,
  parameter int SEL_W     = 3
) (
  input  logic [NUM_PORTS*PINS-1:0] gpio_i,
  input  logic [PINS*SEL_W-1:0]     sel_i,
  output logic [PINS-1:0]           line_o
);
  for (genvar n = 0; n < PINS; n++) begin : g_pin
    logic [SEL_W-1:0]     sel;
    logic [NUM_PORTS-1:0] column;
    assign sel = sel_i[n*SEL_W +: SEL_W];
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      assign column[p] = gpio_i[p*PINS + n];
    end
    // out-of-range port codes park the line low
    assign line_o[n] = (int'(sel) < NUM_PORTS) ? column[sel] : 1'b0;
  end
endmodule

// File: rtl/xirq_edge_capture.sv
module xirq_edge_capture #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic rise_o,
  output logic fall_o
);
  logic rise_tog, fall_tog;
  logic [SYNC_STAGES:0] rise_sync, fall_sync;

  // toggles clocked by the line itself: no pulse is too short to flip them
  always_ff @(posedge line_i or negedge rst_n) begin
    if (!rst_n) rise_tog <= 1'b0;
    else        rise_tog <= ~rise_tog;
  end

  always_ff @(negedge line_i or negedge rst_n) begin
    if (!rst_n) fall_tog <= 1'b0;
    else        fall_tog <= ~fall_tog;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_sync <= '0;
      fall_sync <= '0;
    end else begin
      rise_sync <= {rise_sync[SYNC_STAGES-1:0], rise_tog};
      fall_sync <= {fall_sync[SYNC_STAGES-1:0], fall_tog};
    end
  end

  assign rise_o = rise_sync[SYNC_STAGES] ^ rise_sync[SYNC_STAGES-1];
  assign fall_o = fall_sync[SYNC_STAGES] ^ fall_sync[SYNC_STAGES-1];
endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
  import xirq_pkg::*;
#(
  parameter int NUM_LINES = 19,
  parameter int PIN_LINES = 16,
  parameter int SEL_W     = 3,
  parameter int DATA_W    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [REG_ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata,
  input  logic [NUM_LINES-1:0]     hw_trig_i,
  output logic [NUM_LINES-1:0]     int_en_o,
  output logic [NUM_LINES-1:0]     evt_en_o,
  output logic [NUM_LINES-1:0]     rise_en_o,
  output logic [NUM_LINES-1:0]     fall_en_o,
  output logic [PIN_LINES*SEL_W-1:0] sel_o,
  output logic [NUM_LINES-1:0]     pend_o,
  output logic                     event_o
);
  localparam int SEL_BITS = PIN_LINES * SEL_W;
  localparam int SEL_HALF = SEL_BITS / 2;

  logic [NUM_LINES-1:0] int_en_q, evt_en_q, rise_en_q, fall_en_q, pend_q;
  logic [SEL_BITS-1:0]  sel_q;
  logic                 event_q;
  logic [NUM_LINES-1:0] sw_trig, clr_mask, trig;
  logic                 unused_wdata;

  assign unused_wdata = ^wdata[DATA_W-1:SEL_HALF];

  assign sw_trig  = (wr_en && addr == A_SW_TRIG) ? wdata[NUM_LINES-1:0] : '0;
  assign clr_mask = (wr_en && addr == A_PEND)    ? wdata[NUM_LINES-1:0] : '0;
  assign trig     = hw_trig_i | sw_trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_en_q  <= '0;
      evt_en_q  <= '0;
      rise_en_q <= '0;
      fall_en_q <= '0;
      sel_q     <= '0;
      pend_q    <= '0;
      event_q   <= 1'b0;
    end else begin
      // set beats clear on the same edge
      pend_q  <= (pend_q & ~clr_mask) | (trig & int_en_q);
      event_q <= |(trig & evt_en_q);
      if (wr_en) begin
        unique case (addr)
          A_INT_EN:  int_en_q  <= wdata[NUM_LINES-1:0];
          A_EVT_EN:  evt_en_q  <= wdata[NUM_LINES-1:0];
          A_RISE_EN: rise_en_q <= wdata[NUM_LINES-1:0];
          A_FALL_EN: fall_en_q <= wdata[NUM_LINES-1:0];
          A_SEL_LO:  sel_q[0 +: SEL_HALF]        <= wdata[SEL_HALF-1:0];
          A_SEL_HI:  sel_q[SEL_HALF +: SEL_HALF] <= wdata[SEL_HALF-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (addr)
      A_INT_EN:  rdata = DATA_W'(int_en_q);
      A_EVT_EN:  rdata = DATA_W'(evt_en_q);
      A_RISE_EN: rdata = DATA_W'(rise_en_q);
      A_FALL_EN: rdata = DATA_W'(fall_en_q);
      A_PEND:    rdata = DATA_W'(pend_q);
      A_SEL_LO:  rdata = DATA_W'(sel_q[0 +: SEL_HALF]);
      A_SEL_HI:  rdata = DATA_W'(sel_q[SEL_HALF +: SEL_HALF]);
      default:   rdata = '0;
    endcase
  end

  assign int_en_o  = int_en_q;
  assign evt_en_o  = evt_en_q;
  assign rise_en_o = rise_en_q;
  assign fall_en_o = fall_en_q;
  assign sel_o     = sel_q;
  assign pend_o    = pend_q;
  assign event_o   = event_q;
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
  import xirq_pkg::*;
#(
  parameter int NUM_LINES   = 19,
  parameter int PIN_LINES   = 16,
  parameter int NUM_PORTS   = 5,
  parameter int SEL_W       = 3,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_PORTS*PIN_LINES-1:0] gpio_i,
  input  logic [NUM_LINES-PIN_LINES-1:0] aux_i,
  input  logic                           bus_wr,
  input  logic [REG_ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  output logic [DATA_W-1:0]              bus_rdata,
  output logic [NUM_LINES-1:0]           irq_o,
  output logic                           event_o
);
  logic [PIN_LINES*SEL_W-1:0] sel;
  logic [PIN_LINES-1:0]       pin_lines;
  logic [NUM_LINES-1:0]       lines, rise_raw, fall_raw, hw_trig;
  logic [NUM_LINES-1:0]       int_en, evt_en, rise_en, fall_en;

  xirq_pin_mux #(.NUM_PORTS(NUM_PORTS), .PINS(PIN_LINES), .SEL_W(SEL_W)) u_mux (
    .gpio_i(gpio_i), .sel_i(sel), .line_o(pin_lines)
  );

  assign lines = {aux_i, pin_lines};

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    xirq_edge_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
      .clk(clk), .rst_n(rst_n), .line_i(lines[i]),
      .rise_o(rise_raw[i]), .fall_o(fall_raw[i])
    );
  end

  assign hw_trig = (rise_raw & rise_en) | (fall_raw & fall_en);

  xirq_regs #(
    .NUM_LINES(NUM_LINES), .PIN_LINES(PIN_LINES), .SEL_W(SEL_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .hw_trig_i(hw_trig),
    .int_en_o(int_en), .evt_en_o(evt_en), .rise_en_o(rise_en),
    .fall_en_o(fall_en), .sel_o(sel), .pend_o(irq_o), .event_o(event_o)
  );
endmodule

// File: rtl/xirq_ctrl_chk.sv
module xirq_ctrl_chk #(
  parameter int NUM_LINES = 19,
  parameter int DATA_W    = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_wr,
  input logic [2:0]           bus_addr,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic [DATA_W-1:0]    bus_rdata,
  input logic [NUM_LINES-1:0] irq_o,
  input logic                 event_o,
  input logic [NUM_LINES-1:0] hw_trig,
  input logic [NUM_LINES-1:0] rise_en,
  input logic [NUM_LINES-1:0] fall_en,
  input logic [NUM_LINES-1:0] int_en,
  input logic [NUM_LINES-1:0] evt_en
);
  logic [NUM_LINES-1:0] sw_mask;
  logic                 unused_hi;
  assign sw_mask   = (bus_wr && bus_addr == 3'd4) ? bus_wdata[NUM_LINES-1:0] : '0;
  assign unused_hi = ^bus_wdata[DATA_W-1:NUM_LINES];

  assert_pend_needs_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o & ~$past(irq_o) & ~$past(int_en)) == '0));

  assert_quiet_when_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o & ~$past(irq_o) & ~$past(rise_en | fall_en) & ~$past(sw_mask)) == '0));

  assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd5) |=>
      ((irq_o & $past(bus_wdata[NUM_LINES-1:0]) & ~$past(hw_trig)) == '0));

  assert_trigger_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hw_trig & int_en)) |=>
      ((irq_o & $past(hw_trig & int_en)) == $past(hw_trig & int_en)));

  assert_event_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |-> $past(|((hw_trig | sw_mask) & evt_en)));

  assert_swtrig_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd4) |-> (bus_rdata == '0));
endmodule

bind xirq_ctrl xirq_ctrl_chk #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
  .event_o(event_o), .hw_trig(hw_trig), .rise_en(rise_en),
  .fall_en(fall_en), .int_en(int_en), .evt_en(evt_en)
);

// File: tb/xirq_ctrl_test.sv
`timescale 1ns/100ps
module xirq_ctrl_test;
  localparam int N = 19;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [79:0] gpio = '0;
  logic [2:0]  aux = '0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] irq;
  logic        evt;

  xirq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .gpio_i(gpio), .aux_i(aux),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq), .event_o(evt)
  );

  always #2.5 clk = ~clk;

  int total = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  logic [N-1:0] m_int = '0, m_evten = '0, m_rise = '0, m_fall = '0, m_pend = '0;
  logic         m_evt = 1'b0;
  int           m_sel [16];
  logic [N-1:0] cur_r = '0, cur_f = '0, p1_r = '0, p1_f = '0, p2_r = '0, p2_f = '0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    logic [N-1:0] sw, clr, trig;
    @(posedge clk);
    sw   = (bus_wr && bus_addr == 3'd4) ? bus_wdata[N-1:0] : '0;
    clr  = (bus_wr && bus_addr == 3'd5) ? bus_wdata[N-1:0] : '0;
    trig = (p2_r & m_rise) | (p2_f & m_fall) | sw;
    m_evt  = |(trig & m_evten);
    m_pend = (m_pend & ~clr) | (trig & m_int);
    p2_r = p1_r; p2_f = p1_f; p1_r = cur_r; p1_f = cur_f; cur_r = '0; cur_f = '0;
    if (bus_wr) begin
      case (bus_addr)
        3'd0: m_int   = bus_wdata[N-1:0];
        3'd1: m_evten = bus_wdata[N-1:0];
        3'd2: m_rise  = bus_wdata[N-1:0];
        3'd3: m_fall  = bus_wdata[N-1:0];
        3'd6: for (int k = 0; k < 8; k++) m_sel[k]   = int'(bus_wdata[3*k +: 3]);
        3'd7: for (int k = 0; k < 8; k++) m_sel[k+8] = int'(bus_wdata[3*k +: 3]);
        default: ;
      endcase
    end
    #1;
    check(irq == m_pend, "R6 irq_o vs model", 32'(irq), 32'(m_pend));
    check(evt == m_evt, "R8 event_o vs model", 32'(evt), 32'(m_evt));
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    check(bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  task automatic note_edge(input int line, input logic oldv, input logic newv);
    if (!oldv && newv) cur_r[line] = 1'b1;
    if (oldv && !newv) cur_f[line] = 1'b1;
  endtask

  task automatic set_gpio(input int p, input int n, input logic v);
    logic old;
    old = gpio[p*16+n];
    gpio[p*16+n] = v;
    if (m_sel[n] == p) note_edge(n, old, v);
  endtask

  task automatic set_aux(input int k, input logic v);
    logic old;
    old = aux[k];
    aux[k] = v;
    note_edge(16 + k, old, v);
  endtask

  // narrow pulse: both edges inside one clock period
  task automatic pulse_gpio(input int p, input int n);
    set_gpio(p, n, 1'b1);
    #1;
    set_gpio(p, n, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 16; k++) m_sel[k] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // reset state (R10)
    check(irq == '0, "R10 irq after reset", 32'(irq), 0);
    check(evt == 1'b0, "R10 event after reset", 32'(evt), 0);
    for (int a = 0; a < 8; a++) rd(3'(a), 0, "R10 reset read");
    tick();

    wr(3'd0, 32'h7FFFF);
    rd(3'd0, 32'h7FFFF, "R10 int_en readback");
    wr(3'd2, 32'h00008);

    // R2/R5: narrow rising pulse on line 3, due after third edge
    pulse_gpio(0, 3);
    ticks(2);
    check(irq[3] == 1'b0, "R5 not yet pending", 32'(irq[3]), 0);
    tick();
    check(irq[3] == 1'b1, "R2 R5 pending after 3 edges", 32'(irq[3]), 1);

    // R7: write 0 keeps, write 1 clears
    wr(3'd5, 32'h0);
    check(irq[3] == 1'b1, "R7 zero write no effect", 32'(irq[3]), 1);
    wr(3'd5, 32'h8);
    check(irq[3] == 1'b0, "R7 w1c clears", 32'(irq[3]), 0);

    // R3: falling only on line 4
    wr(3'd3, 32'h10);
    set_gpio(0, 4, 1'b1);
    ticks(4);
    check(irq[4] == 1'b0, "R3 rise ignored", 32'(irq[4]), 0);
    set_gpio(0, 4, 1'b0);
    ticks(3);
    check(irq[4] == 1'b1, "R3 fall triggers", 32'(irq[4]), 1);

    // R2/R3: both edges on line 6
    wr(3'd2, 32'h48);
    wr(3'd3, 32'h50);
    set_gpio(0, 6, 1'b1);
    ticks(3);
    check(irq[6] == 1'b1, "R2 both: rise", 32'(irq[6]), 1);
    wr(3'd5, 32'h40);
    set_gpio(0, 6, 1'b0);
    ticks(3);
    check(irq[6] == 1'b1, "R3 both: fall", 32'(irq[6]), 1);

    // R4: line 7 with no enables
    pulse_gpio(0, 7);
    ticks(4);
    check(irq[7] == 1'b0, "R4 disabled line quiet", 32'(irq[7]), 0);

    // R6/R8: line 8 masked for interrupt, enabled for event
    wr(3'd0, 32'h7FEFF);
    wr(3'd1, 32'h100);
    wr(3'd2, 32'h148);
    pulse_gpio(0, 8);
    ticks(3);
    check(evt == 1'b1, "R8 event pulse", 32'(evt), 1);
    check(irq[8] == 1'b0, "R6 masked no pending", 32'(irq[8]), 0);
    tick();
    check(evt == 1'b0, "R8 event one cycle", 32'(evt), 0);

    // R1: line 5 routed from port 3, then an invalid code
    wr(3'd6, 32'(3) << 15);
    rd(3'd6, 32'(3) << 15, "R10 select readback");
    wr(3'd2, 32'h168);
    pulse_gpio(0, 5);
    ticks(4);
    check(irq[5] == 1'b0, "R1 unselected port ignored", 32'(irq[5]), 0);
    pulse_gpio(3, 5);
    ticks(3);
    check(irq[5] == 1'b1, "R1 selected port triggers", 32'(irq[5]), 1);
    wr(3'd5, 32'h20);
    wr(3'd6, 32'(6) << 15);
    for (int p = 0; p < 5; p++) begin
      pulse_gpio(p, 5);
      tick();
    end
    ticks(3);
    check(irq[5] == 1'b0, "R1 invalid port code low", 32'(irq[5]), 0);

    // R1: direct line 17
    wr(3'd2, 32'h20168);
    set_aux(1, 1'b1);
    #1 set_aux(1, 1'b0);
    ticks(3);
    check(irq[17] == 1'b1, "R1 aux line", 32'(irq[17]), 1);

    // R9: software trigger
    wr(3'd4, 32'h400);
    check(irq[10] == 1'b1, "R9 sw trigger pending", 32'(irq[10]), 1);
    rd(3'd4, 0, "R9 sw trigger reads zero");
    wr(3'd4, 32'h100);
    check(irq[8] == 1'b0, "R9 R6 sw masked line", 32'(irq[8]), 0);
    check(evt == 1'b1, "R9 R8 sw event", 32'(evt), 1);

    // R7: trigger on the clear edge wins
    pulse_gpio(0, 3);
    ticks(3);
    check(irq[3] == 1'b1, "R7 setup pending", 32'(irq[3]), 1);
    pulse_gpio(0, 3);
    ticks(2);
    wr(3'd5, 32'h8);
    check(irq[3] == 1'b1, "R7 set beats clear", 32'(irq[3]), 1);
    wr(3'd5, 32'h8);
    check(irq[3] == 1'b0, "R7 later clear", 32'(irq[3]), 0);
    ticks(4);

    finish_run();
  end
endmodule